// File: doc/BRIEF.md
# Framed Serial Transmit Sequencer

This block turns bytes written by a host into a serial bit stream, one bit per pulse of a bit-rate enable. When transmission is switched on it first sends alternating ones and zeros as a synchronisation preamble. It then sends each host byte most significant bit first. A single-entry holding register lets the host refill one byte ahead of the shifter. A data-ready flag with its own interrupt tells the host when to refill.

With check insertion armed, the sequencer counts the data bytes it moves into the shifter. After every six of them it sends a two-byte check word. The check word comes from an external generator. The sequencer drives that generator with a start pulse and a strobed bit stream, and reads back the 16-bit result. If the host stops supplying bytes, the sequencer sends one hang bit and then raises an idle flag with an interrupt. An incomplete check group is abandoned and no check word is sent. A later host write resumes transmission from idle.

Top module: `tx_frame_seq`

## Requirements
- R1: A rising edge on `tx_en` raises `drive_en` on the next clock. A preamble then starts at once with a 1 bit, alternating 1,0 (byte value 0xAA), and at least one whole preamble byte is sent.
- R2: While no byte is waiting in the holding register at the end of a preamble byte, further whole 0xAA preamble bytes follow.
- R3: Bytes leave most significant bit first. `rdy_flag` sets on the clock after `tx_en` rises, with `rdy_irq` staying low. `rdy_flag` and `rdy_irq` both set when a held byte moves into the shifter. A host write clears `rdy_flag`.
- R4: After a 0-to-1 change of `chk_en`, every sixth data byte moved into the shifter is followed by `chk_word[15:8]` and then `chk_word[7:0]`. This repeats while `chk_en` stays high. `chk_start` pulses in the cycle the first byte of each group is loaded, and after that each bit of a grouped byte is offered once on `chk_bit` with `chk_bit_vld` high.
- R5: If the holding register is empty at a byte end while a group holds fewer than six bytes, no check word is sent.
- R6: After the last data or check byte, a single 0 hang bit is sent. `idle_flag` and `idle_irq` set at the bit tick that ends the hang bit.
- R7: A host write clears `idle_flag`. A byte written while idle is loaded at the next bit tick and is followed again by a hang bit.
- R8: While `tx_en` is low, `drive_en` and `ser_out` are 0, all flags and interrupts clear on the next clock, and host writes are discarded.
- R9: `stat_rd` clears `rdy_irq` and `idle_irq` but not the flags. An interrupt being set in the same cycle as `stat_rd` stays set.
- R10: With `chk_en` low, bytes go out exactly as written, with no check bytes.
- R11: `byte_tick` pulses once at the bit tick that ends each preamble, data or check byte, and only together with `bit_tick`.
- R12: After reset, `drive_en`, `ser_out`, all flags and all interrupts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-clock pulse per bit period, never in consecutive clocks |
| tx_en | input | 1 | Transmit enable |
| chk_en | input | 1 | Check-word insertion enable, armed on its rising edge |
| wr_stb | input | 1 | Host byte write strobe |
| wr_data | input | 8 | Host byte |
| stat_rd | input | 1 | Status-read strobe, clears interrupts |
| chk_word | input | 16 | Result from the external check generator |
| ser_out | output | 1 | Serial bit |
| drive_en | output | 1 | Output drive enable; low means released |
| rdy_flag | output | 1 | Holding register may be refilled |
| rdy_irq | output | 1 | Data-ready interrupt request |
| idle_flag | output | 1 | All data and the hang bit have been sent |
| idle_irq | output | 1 | Idle interrupt request |
| byte_tick | output | 1 | Pulse at each byte end |
| chk_start | output | 1 | Restart the external check generator |
| chk_bit_vld | output | 1 | `chk_bit` carries a grouped data bit |
| chk_bit | output | 1 | Data bit for the check generator |

## Verification
Two functions can fall in the same cycle: the status-read clear of an interrupt, and the setting of that interrupt by the hang bit finishing. The bench provokes this by holding `stat_rd` high continuously from the last byte transfer until `idle_flag` rises. It then judges that `idle_irq` is still 1 in that cycle, and that a later single read clears the interrupt while leaving the flag set. The host write that clears idle is also checked against the idle-resume path, which loads the written byte on the following bit tick.

// File: rtl/tfs_pkg.sv
// Shared types and helpers for the framed serial transmit sequencer.
// Assumes nothing beyond IEEE 1800-2017 packages.
package tfs_pkg;

    typedef enum logic [2:0] {
        ST_OFF  = 3'd0,
        ST_PRE  = 3'd1,
        ST_DATA = 3'd2,
        ST_CHKH = 3'd3,
        ST_CHKL = 3'd4,
        ST_HANG = 3'd5,
        ST_IDLE = 3'd6
    } tx_state_t;

    // Alternating pattern with a 1 in the top bit of a w-bit field.
    function automatic logic [31:0] alt_bits(input int w);
        logic [31:0] v;
        v = '0;
        for (int i = 0; i < w; i++) begin
            v[i] = ((w - 1 - i) % 2) == 0;
        end
        return v;
    endfunction

endpackage

// File: rtl/tfs_shift.sv
// Output shift register with a bit counter.
// Loads a parallel value, shifts left one place per request and flags the last bit.
// Assumes clear has priority over load, and load over shift.
module tfs_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         msb,
    output logic         last
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0]  sr_q;
    logic [CW-1:0] cnt_q;

    // Shift register and bit position update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (load) begin
            sr_q  <= load_val;
            cnt_q <= '0;
        end else if (shift) begin
            sr_q  <= {sr_q[W-2:0], 1'b0};
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign msb  = sr_q[W-1];
    assign last = (cnt_q == CW'(W - 1));
endmodule

// File: rtl/tfs_hold.sv
// Host holding register plus the data-ready and idle flags with their interrupts.
// Assumes 'on' is the live transmit enable and 'rise' its one-cycle rising edge.
// Writes while off are discarded; a set wins over a status-read clear.
module tfs_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         on,
    input  logic         rise,
    input  logic         wr,
    input  logic [W-1:0] wr_data,
    input  logic         take,
    input  logic         idle_set,
    input  logic         stat_rd,
    output logic [W-1:0] hold_q,
    output logic         full,
    output logic         rdy_flag,
    output logic         rdy_irq,
    output logic         idle_flag,
    output logic         idle_irq
);
    // Holding data register, written only while transmitting.
    always_ff @(posedge clk) begin
        if (!rst_n)          hold_q <= '0;
        else if (wr && on)   hold_q <= wr_data;
    end

    // Occupancy: a write in the same cycle as a transfer keeps the new byte.
    always_ff @(posedge clk) begin
        if (!rst_n || !on)   full <= 1'b0;
        else if (wr)         full <= 1'b1;
        else if (take)       full <= 1'b0;
    end

    // Data-ready flag: set on enable or transfer, cleared by a write.
    always_ff @(posedge clk) begin
        if (!rst_n || !on)      rdy_flag <= 1'b0;
        else if (rise || take)  rdy_flag <= 1'b1;
        else if (wr)            rdy_flag <= 1'b0;
    end

    // Data-ready interrupt: set on transfer only.
    always_ff @(posedge clk) begin
        if (!rst_n || !on)   rdy_irq <= 1'b0;
        else if (take)       rdy_irq <= 1'b1;
        else if (stat_rd)    rdy_irq <= 1'b0;
    end

    // Idle flag: set after the hang bit, cleared by a write.
    always_ff @(posedge clk) begin
        if (!rst_n || !on)   idle_flag <= 1'b0;
        else if (idle_set)   idle_flag <= 1'b1;
        else if (wr)         idle_flag <= 1'b0;
    end

    // Idle interrupt: set after the hang bit, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n || !on)   idle_irq <= 1'b0;
        else if (idle_set)   idle_irq <= 1'b1;
        else if (stat_rd)    idle_irq <= 1'b0;
    end
endmodule

// File: rtl/tfs_group.sv
// Check-group counter. Arms on a rising check enable and counts data bytes
// loaded into the shifter, reporting a full group after GROUP_LEN of them.
// Assumes 'clr_grp' is pulsed when a check word starts or a group is abandoned.
module tfs_group #(
    parameter int GROUP_LEN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic chk_en,
    input  logic on,
    input  logic data_load,
    input  logic clr_grp,
    output logic grouping,
    output logic group_full,
    output logic start
);
    localparam int GW = $clog2(GROUP_LEN + 1);

    logic          chk_q;
    logic          armed_q;
    logic [GW-1:0] gc_q;
    logic          chk_rise;

    assign chk_rise = chk_en && !chk_q;

    // Previous check enable for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) chk_q <= 1'b0;
        else        chk_q <= chk_en;
    end

    // Arming: set by a 0-to-1 change, dropped when the enable falls.
    always_ff @(posedge clk) begin
        if (!rst_n || !chk_en) armed_q <= 1'b0;
        else if (chk_rise)     armed_q <= 1'b1;
    end

    // Byte count within the current group.
    always_ff @(posedge clk) begin
        if (!rst_n || !on || !chk_en || chk_rise || clr_grp) gc_q <= '0;
        else if (data_load && armed_q)                       gc_q <= gc_q + 1'b1;
    end

    assign grouping   = armed_q;
    assign group_full = armed_q && (gc_q == GW'(GROUP_LEN));
    assign start      = armed_q && data_load && (gc_q == '0);
endmodule

// File: rtl/tx_frame_seq.sv
// Framed serial transmit sequencer top.
// Sends preamble, host bytes MSB first, optional 2-byte check words per group,
// and a hang bit before idling. Assumes bit_tick never occurs on two
// consecutive clocks, so the external generator has a clock to absorb each bit.
module tx_frame_seq #(
    parameter int DATA_W    = 8,
    parameter int GROUP_LEN = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bit_tick,
    input  logic                  tx_en,
    input  logic                  chk_en,
    input  logic                  wr_stb,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  stat_rd,
    input  logic [2*DATA_W-1:0]   chk_word,
    output logic                  ser_out,
    output logic                  drive_en,
    output logic                  rdy_flag,
    output logic                  rdy_irq,
    output logic                  idle_flag,
    output logic                  idle_irq,
    output logic                  byte_tick,
    output logic                  chk_start,
    output logic                  chk_bit_vld,
    output logic                  chk_bit
);
    import tfs_pkg::*;

    localparam int CHK_W = 2 * DATA_W;
    localparam logic [DATA_W-1:0] PRE_PAT = DATA_W'(alt_bits(DATA_W));

    tx_state_t         state_q, nxt;
    logic              tx_en_q, rise;
    logic              ld, take, data_ld, chk_ld, abort, idle_set, shift, clr, boundary;
    logic [DATA_W-1:0] ld_val, hold_q;
    logic              full, msb, last;
    logic              grouping, group_full;
    logic              in_grp_q, feed_q;

    assign rise = tx_en && !tx_en_q;

    // Previous transmit enable for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_en_q <= 1'b0;
        else        tx_en_q <= tx_en;
    end

    // Next-state and shifter command decode.
    always_comb begin
        nxt      = state_q;
        ld       = 1'b0;
        ld_val   = '0;
        take     = 1'b0;
        data_ld  = 1'b0;
        chk_ld   = 1'b0;
        abort    = 1'b0;
        idle_set = 1'b0;
        shift    = 1'b0;
        clr      = 1'b0;
        boundary = 1'b0;
        if (!tx_en) begin
            nxt = ST_OFF;
            clr = 1'b1;
        end else if (rise) begin
            nxt    = ST_PRE;
            ld     = 1'b1;
            ld_val = PRE_PAT;
        end else begin
            case (state_q)
                ST_PRE, ST_DATA, ST_CHKH, ST_CHKL: begin
                    if (bit_tick) begin
                        if (!last) begin
                            shift = 1'b1;
                        end else begin
                            boundary = 1'b1;
                            ld       = 1'b1;
                            if (state_q == ST_DATA && group_full) begin
                                nxt    = ST_CHKH;
                                ld_val = chk_word[CHK_W-1 -: DATA_W];
                                chk_ld = 1'b1;
                            end else if (state_q == ST_CHKH) begin
                                nxt    = ST_CHKL;
                                ld_val = chk_word[DATA_W-1:0];
                            end else if (full) begin
                                nxt     = ST_DATA;
                                ld_val  = hold_q;
                                take    = 1'b1;
                                data_ld = 1'b1;
                            end else if (state_q == ST_PRE) begin
                                ld_val = PRE_PAT;
                            end else begin
                                nxt    = ST_HANG;
                                ld_val = '0;
                                abort  = 1'b1;
                            end
                        end
                    end
                end
                ST_HANG: begin
                    if (bit_tick) begin
                        nxt      = ST_IDLE;
                        idle_set = 1'b1;
                        clr      = 1'b1;
                    end
                end
                ST_IDLE: begin
                    if (bit_tick && full) begin
                        nxt     = ST_DATA;
                        ld      = 1'b1;
                        ld_val  = hold_q;
                        take    = 1'b1;
                        data_ld = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= nxt;
    end

    // Marks that the byte in the shifter belongs to a check group.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) in_grp_q <= 1'b0;
        else if (ld)       in_grp_q <= data_ld && grouping;
    end

    // Strobe for the generator: one per grouped bit newly on the line.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) feed_q <= 1'b0;
        else               feed_q <= (data_ld && grouping) || (shift && in_grp_q);
    end

    tfs_shift #(.W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .load     (ld),
        .load_val (ld_val),
        .shift    (shift),
        .msb      (msb),
        .last     (last)
    );

    tfs_hold #(.W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .on        (tx_en),
        .rise      (rise),
        .wr        (wr_stb),
        .wr_data   (wr_data),
        .take      (take),
        .idle_set  (idle_set),
        .stat_rd   (stat_rd),
        .hold_q    (hold_q),
        .full      (full),
        .rdy_flag  (rdy_flag),
        .rdy_irq   (rdy_irq),
        .idle_flag (idle_flag),
        .idle_irq  (idle_irq)
    );

    tfs_group #(.GROUP_LEN(GROUP_LEN)) u_group (
        .clk        (clk),
        .rst_n      (rst_n),
        .chk_en     (chk_en),
        .on         (tx_en),
        .data_load  (data_ld),
        .clr_grp    (chk_ld || abort),
        .grouping   (grouping),
        .group_full (group_full),
        .start      (chk_start)
    );

    assign drive_en    = (state_q != ST_OFF);
    assign ser_out     = drive_en && msb;
    assign byte_tick   = boundary;
    assign chk_bit_vld = feed_q;
    assign chk_bit     = msb;
endmodule

// File: rtl/tx_frame_seq_chk.sv
// Property checker for tx_frame_seq, attached by bind.
// Observes ports only; assumes synchronous active-low reset.
module tx_frame_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_tick,
    input logic tx_en,
    input logic chk_en,
    input logic wr_stb,
    input logic ser_out,
    input logic drive_en,
    input logic rdy_flag,
    input logic rdy_irq,
    input logic idle_flag,
    input logic idle_irq,
    input logic byte_tick,
    input logic chk_start
);
    // R8
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (!drive_en && !rdy_flag && !rdy_irq && !idle_flag && !idle_irq));

    // R8
    off_line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_en |-> !ser_out);

    // R3
    en_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |=> (rdy_flag && !rdy_irq && drive_en));

    // R11
    byte_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_tick |-> bit_tick);

    // R6
    idle_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_flag) |-> $past(bit_tick));

    // R4
    start_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_start |-> (chk_en && drive_en));

    // R7
    wr_clears_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && tx_en && !bit_tick) |=> !idle_flag);
endmodule

bind tx_frame_seq tx_frame_seq_chk u_chk (.*);

// File: tb/sim_tx_frame_seq.sv
// Bench: vector table of transmissions followed by directed corner tests.
module sim_tx_frame_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick = 1'b0;
    logic        tx_en = 1'b0;
    logic        chk_en = 1'b0;
    logic        wr_stb = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        stat_rd = 1'b0;
    logic [15:0] chk_word;
    logic        ser_out, drive_en, rdy_flag, rdy_irq, idle_flag, idle_irq;
    logic        byte_tick, chk_start, chk_bit_vld, chk_bit;

    int nchk = 0;
    int nerr = 0;
    int tcnt = 0;
    int cap_n = 0;
    int nbyte = 0;
    int nstart = 0;
    logic cap [0:4095];
    logic [15:0] gen_sr = 16'h0000;

    // mode[15:12] (1 = check insertion), byte count[11:8], seed[7:0]
    localparam logic [15:0] VEC [0:4] = '{16'h0331, 16'h1652, 16'h1C17, 16'h18A4, 16'h01E9};

    always #2 clk = ~clk;

    tx_frame_seq u0 (.*);

    // Bench check generator: keeps the last 16 grouped bits.
    always @(posedge clk) begin
        if (chk_start)        gen_sr <= 16'h0000;
        else if (chk_bit_vld) gen_sr <= {gen_sr[14:0], chk_bit};
    end
    assign chk_word = gen_sr;

    // Bit tick every 4 clocks; capture the line bit that ends at each tick.
    always @(negedge clk) begin
        if (!rst_n) begin
            tcnt = 0;
            bit_tick = 1'b0;
        end else begin
            tcnt = (tcnt + 1) % 4;
            bit_tick = (tcnt == 0);
            if (bit_tick && drive_en) begin
                if (cap_n < 4096) cap[cap_n] = ser_out;
                cap_n++;
            end
        end
    end

    // Count byte ends and generator starts between edges.
    always begin
        @(negedge clk);
        #1;
        if (byte_tick) nbyte++;
        if (chk_start) nstart++;
    end

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_stb = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    function automatic logic [7:0] bval(input logic [7:0] seed, input int i);
        return seed ^ 8'(i * 37 + 5);
    endfunction

    function automatic logic [7:0] cap_byte(input int idx);
        logic [7:0] v = 8'h00;
        for (int b = 0; b < 8; b++) v = {v[6:0], cap[idx + b]};
        return v;
    endfunction

    task automatic wait_idle();
        while (!idle_flag) @(negedge clk);
    endtask

    task automatic turn_off();
        @(negedge clk);
        tx_en = 1'b0;
        chk_en = 1'b0;
        @(negedge clk);
        check("R8 drive_en off", drive_en, 0);
        check("R8 flags off", {rdy_flag, rdy_irq, idle_flag, idle_irq}, 0);
    endtask

    task automatic run_vec(input logic [15:0] v);
        int mode = int'(v[15:12]);
        int n    = int'(v[11:8]);
        logic [7:0] seed = v[7:0];
        logic [7:0] exp_b [0:31];
        int ne = 0;
        int base, got, b0, s0;
        base = cap_n; b0 = nbyte; s0 = nstart;
        exp_b[ne++] = 8'hAA;
        for (int i = 0; i < n; i++) begin
            exp_b[ne++] = bval(seed, i);
            if (mode == 1 && (i % 6) == 5) begin
                exp_b[ne++] = bval(seed, i - 1);
                exp_b[ne++] = bval(seed, i);
            end
        end
        @(negedge clk);
        tx_en = 1'b1;
        @(negedge clk);
        if (mode == 1) chk_en = 1'b1;
        check("R3 ready on enable", rdy_flag, 1);
        check("R3 no irq on enable", rdy_irq, 0);
        check("R1 drive_en on", drive_en, 1);
        for (int i = 0; i < n; i++) begin
            while (!rdy_flag) @(negedge clk);
            if (i == 1) check("R3 irq on transfer", rdy_irq, 1);
            wr(bval(seed, i));
        end
        while (!rdy_flag) @(negedge clk);
        stat_rd = 1'b1;
        wait_idle();
        got = cap_n - base;
        check("R9 set wins over read", idle_irq, 1);
        stat_rd = 1'b0;
        @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        check("R9 read clears idle irq", idle_irq, 0);
        check("R9 read keeps idle flag", idle_flag, 1);
        check("R4 R5 R10 bit count", got, ne * 8 + 1);
        if (got == ne * 8 + 1) begin
            for (int k = 0; k < ne; k++)
                check(k == 0 ? "R1 preamble byte" : (mode == 1 ? "R4 R5 byte" : "R10 byte"),
                      int'(cap_byte(base + 8 * k)), int'(exp_b[k]));
            check("R6 hang bit", int'(cap[base + ne * 8]), 0);
        end
        check("R11 byte ticks", nbyte - b0, ne);
        check("R4 group starts", nstart - s0, (mode == 1) ? (n + 5) / 6 : 0);
        turn_off();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        int base, b0, got;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check("R12 drive_en", drive_en, 0);
        check("R12 ser_out", ser_out, 0);
        check("R12 flags", {rdy_flag, rdy_irq, idle_flag, idle_irq}, 0);

        for (int t = 0; t < 5; t++) run_vec(VEC[t]);

        // R8 write while off is discarded; R2 preamble repeats until data
        wr(8'h00);
        base = cap_n; b0 = nbyte;
        @(negedge clk);
        tx_en = 1'b1;
        while (nbyte - b0 < 2) @(negedge clk);
        check("R8 write while off ignored", rdy_flag, 1);
        wr(8'hC3);
        wait_idle();
        got = cap_n - base;
        check("R2 bit count", got, 33);
        if (got == 33) begin
            for (int k = 0; k < 3; k++) check("R2 extra preamble", int'(cap_byte(base + 8 * k)), 8'hAA);
            check("R3 msb first", int'(cap_byte(base + 24)), 8'hC3);
            check("R6 hang bit", int'(cap[base + 32]), 0);
        end

        // R7 resume from idle
        base = cap_n;
        wr(8'h5A);
        check("R7 write clears idle", idle_flag, 0);
        wait_idle();
        got = cap_n - base;
        check("R7 enough bits", int'(got >= 9), 1);
        if (got >= 9) begin
            check("R7 resumed byte", int'(cap_byte(cap_n - 9)), 8'h5A);
            check("R7 hang after resume", int'(cap[cap_n - 1]), 0);
        end
        turn_off();

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule